// File: doc/BRIEF.md
# Voltage DAC Register Front End

This block sits between a simple register bus and an on-chip voltage DAC. It holds two registers: a control word and a data word. From them it produces the code word that the converter latches, plus static control lines for power-down, the buffer modes and the output range. The analog converter, output buffer and interpolation filter are outside the block. They see only these outputs.

The control word chooses how the latched code is updated. It can follow the data register on every system clock, or it can load only when an external timer output rises. The timer pacing lets software preload the next sample of a waveform. A clear bit forces the data register and the latched code to zero at the edge that writes it, and holds them there. The block also turns a peripheral-clock enable pulse into an interpolation clock enable at one sixteenth or one thirty-second of that rate.

Top module: `dac_frontend`

## Requirements
- R1: After reset the control register reads 0x0200, the data register reads 0, code_o is 0, out_en_o is 0 and interp_en_o is 0.
- R2: Control bits 15:10 always read 0, and writes to them have no effect. Bus address 0 selects the control register and address 1 selects the data register.
- R3: out_en_o is the inverse of control bit 9. buf_lp_o follows bit 8, opamp_o follows bit 7, buf_bypass_o follows bit 6, interp_mode_o follows bit 3, and range_o follows bits 1:0.
- R4: When control bit 5 is 0 and bit 4 is 1, code_o takes the data register value one clock after the data register changes.
- R5: When control bit 5 is 1, code_o loads only at the third rising clock edge after timer_i rises, counted from the first edge that samples it high. It holds its value at all other times, and a timer_i that stays high causes no further loads.
- R6: A control write with bit 4 equal to 0 sets the data register and code_o to 0 at the edge that performs the write.
- R7: While control bit 4 is 0, writes to the data register are ignored and the register reads 0.
- R8: When control bit 3 is 0, code_o is the low 12 bits of the data register with bits 15:12 zero. When bit 3 is 1, code_o carries all 16 bits.
- R9: While control bit 3 is 1, interp_en_o is high together with every 16th pclk_en_i pulse if bit 2 is 1, or with every 32nd pulse if bit 2 is 0. Pulses are counted from the control write that sets bit 3. interp_en_o stays 0 while bit 3 is 0.
- R10: The data register reads back the last value written to it while bit 4 was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 2 | Register select: 0 control, 1 data |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| timer_i | input | 1 | Asynchronous timer output used to pace updates |
| pclk_en_i | input | 1 | One-cycle enable, one pulse per peripheral clock period |
| code_o | output | 16 | Latched converter code |
| out_en_o | output | 1 | Converter output enable (0 = tristated) |
| buf_lp_o | output | 1 | Output buffer low-power select |
| opamp_o | output | 1 | Output buffer op-amp mode select |
| buf_bypass_o | output | 1 | Output buffer bypass select |
| interp_mode_o | output | 1 | 16-bit interpolation mode select |
| range_o | output | 2 | Output range select |
| interp_en_o | output | 1 | Interpolation clock enable pulse |

## Verification
A corrupted control register shows at once on the static control outputs and on the read port. A corrupted data register or update selector shows on code_o one clock after the data register changes in free-running mode. In timer mode it shows on the third edge after a timer rise. A faulty clear path leaves a nonzero code or data readback visible in the cycle right after the clearing write. A divider counting fault moves the first interp_en_o pulse off the 16th or 32nd enable pulse, so the fault shows within one divide period.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned NARROW_W = 12;
  localparam logic [DATA_W-1:0] CTRL_RST = 16'h0200;
  localparam logic [DATA_W-1:0] CTRL_MASK = 16'h03FF;
  // control bit positions
  localparam int unsigned B_PD = 9;
  localparam int unsigned B_BUFLP = 8;
  localparam int unsigned B_OPAMP = 7;
  localparam int unsigned B_BYP = 6;
  localparam int unsigned B_TIMED = 5;
  localparam int unsigned B_RUN = 4;
  localparam int unsigned B_WIDE = 3;
  localparam int unsigned B_FAST = 2;
  typedef enum logic [1:0] {
    RNG_INTREF = 2'b00,
    RNG_REFPIN = 2'b01,
    RNG_EXTREF = 2'b10,
    RNG_SUPPLY = 2'b11
  } range_e;
endpackage

// File: rtl/dac_fe_regs.sv
module dac_fe_regs
  import dac_fe_pkg::*;
#(
  parameter int unsigned AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              clear_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_DATA = AW'(1);

  logic [DATA_W-1:0] ctrl_q, data_q;
  logic wr_ctrl, wr_data;

  assign wr_ctrl = sel_i & we_i & (addr_i == A_CTRL);
  assign wr_data = sel_i & we_i & (addr_i == A_DATA);
  // clear acts at the writing edge, then persists while the run bit is low
  assign clear_o = (wr_ctrl & ~wdata_i[B_RUN]) | ~ctrl_q[B_RUN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else if (wr_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else if (clear_o) data_q <= '0;
    else if (wr_data) data_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) rdata_o = ctrl_q;
    else if (addr_i == A_DATA) rdata_o = data_q;
  end

  assign ctrl_o = ctrl_q;
  assign data_o = data_q;

  p_rsv_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (ctrl_q[DATA_W-1:10] == '0));
  p_clr_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> (data_q == '0));
endmodule

// File: rtl/dac_fe_update.sv
module dac_fe_update
  import dac_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              timer_i,
  input  logic              timed_i,
  input  logic              wide_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] code_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic tick, load;
  logic [DATA_W-1:0] sel_code, code_q;

  assign sync_q[0] = timer_i;
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g+1] <= 1'b0;
      else sync_q[g+1] <= sync_q[g];
    end
  end

  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sync_q[SYNC_STAGES];
  end

  assign tick = sync_q[SYNC_STAGES] & ~prev_q;
  assign load = ~timed_i | tick;
  assign sel_code = wide_i ? data_i : {{(DATA_W-NARROW_W){1'b0}}, data_i[NARROW_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else if (clear_i) code_q <= '0;
    else if (load) code_q <= sel_code;
  end

  assign code_o = code_q;

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (code_q == '0));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed_i && !tick && !clear_i) |=> $stable(code_q));
  p_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!timed_i && !clear_i) |=> (code_q[NARROW_W-1:0] == $past(data_i[NARROW_W-1:0])));
endmodule

// File: rtl/dac_fe_interp_div.sv
module dac_fe_interp_div #(
  parameter int unsigned FAST_DIV = 16,
  parameter int unsigned SLOW_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  input  logic pclk_en_i,
  output logic en_o
);
  localparam int unsigned CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] FAST_M = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] SLOW_M = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (pclk_en_i) cnt_q <= cnt_q + 1'b1;
  end

  // both divisors are powers of two, so masking the free count suffices
  assign term = fast_i ? ((cnt_q & FAST_M) == FAST_M) : (cnt_q == SLOW_M);
  assign en_o = run_i & pclk_en_i & term;

  p_en_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (pclk_en_i && run_i));
  p_no_back2back_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> !en_o);
endmodule

// File: rtl/dac_frontend.sv
module dac_frontend
  import dac_fe_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FAST_DIV = 16,
  parameter int unsigned SLOW_DIV = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              timer_i,
  input  logic              pclk_en_i,
  output logic [DATA_W-1:0] code_o,
  output logic              out_en_o,
  output logic              buf_lp_o,
  output logic              opamp_o,
  output logic              buf_bypass_o,
  output logic              interp_mode_o,
  output logic [1:0]        range_o,
  output logic              interp_en_o
);
  logic [DATA_W-1:0] ctrl, data;
  logic clear;

  dac_fe_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .ctrl_o(ctrl), .data_o(data), .clear_o(clear)
  );

  dac_fe_update #(.SYNC_STAGES(SYNC_STAGES)) u_upd (
    .clk_i, .rst_ni, .timer_i,
    .timed_i(ctrl[B_TIMED]), .wide_i(ctrl[B_WIDE]), .clear_i(clear),
    .data_i(data), .code_o
  );

  dac_fe_interp_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
    .clk_i, .rst_ni, .run_i(ctrl[B_WIDE]), .fast_i(ctrl[B_FAST]),
    .pclk_en_i, .en_o(interp_en_o)
  );

  assign out_en_o = ~ctrl[B_PD];
  assign buf_lp_o = ctrl[B_BUFLP];
  assign opamp_o = ctrl[B_OPAMP];
  assign buf_bypass_o = ctrl[B_BYP];
  assign interp_mode_o = ctrl[B_WIDE];
  assign range_o = ctrl[1:0];

  p_narrow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !interp_mode_o |=> (code_o[DATA_W-1:NARROW_W] == '0));
  p_pd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_we_i && bus_addr_i == AW'(0)) |=> (out_en_o == !$past(bus_wdata_i[B_PD])));
endmodule

// File: tb/sim_dac_frontend.sv
module sim_dac_frontend;
  logic clk = 0, rst_ni = 0;
  logic bus_sel_i = 0, bus_we_i = 0;
  logic [1:0] bus_addr_i = 0;
  logic [15:0] bus_wdata_i = 0, bus_rdata_o, code_o;
  logic timer_i = 0, pclk_en_i = 0;
  logic out_en_o, buf_lp_o, opamp_o, buf_bypass_o, interp_mode_o, interp_en_o;
  logic [1:0] range_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_frontend u0 (
    .clk_i(clk), .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .timer_i, .pclk_en_i, .code_o, .out_en_o, .buf_lp_o,
    .opamp_o, .buf_bypass_o, .interp_mode_o, .range_o, .interp_en_o
  );

  // ctrl, data, expected code, expected ctrl readback
  localparam logic [15:0] VEC [7][4] = '{
    '{16'h0010, 16'hABCD, 16'h0BCD, 16'h0010},
    '{16'h0018, 16'hABCD, 16'hABCD, 16'h0018},
    '{16'h0018, 16'h0FFF, 16'h0FFF, 16'h0018},
    '{16'h0010, 16'hF123, 16'h0123, 16'h0010},
    '{16'h0013, 16'h8001, 16'h0001, 16'h0013},
    '{16'h001B, 16'hFFFF, 16'hFFFF, 16'h001B},
    '{16'hFC18, 16'h1234, 16'h1234, 16'h0018}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr_i = a; #1; d = bus_rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); pclk_en_i = 1; #1;
      if (interp_en_o) begin cnt++; if (first < 0) first = i; end
    end
    @(negedge clk); pclk_en_i = 0;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int cnt, first;
    idle(3); rst_ni = 1; @(negedge clk);
    // R1 reset state
    rd(0, r); chk("R1 ctrl", r, 16'h0200);
    rd(1, r); chk("R1 data", r, 16'h0000);
    chk("R1 code", code_o, 16'h0);
    chk("R1 out_en", {15'b0, out_en_o}, 16'h0);
    chk("R1 interp_en", {15'b0, interp_en_o}, 16'h0);

    // table: R2 R4 R8 R10
    for (int i = 0; i < 7; i++) begin
      wr(0, VEC[i][0]);
      wr(1, VEC[i][1]);
      @(negedge clk);
      chk("R4/R8 code", code_o, VEC[i][2]);
      rd(1, r); chk("R10 data", r, VEC[i][1]);
      rd(0, r); chk("R2 ctrl", r, VEC[i][3]);
    end

    // R3 static outputs
    wr(0, 16'h01D3);
    chk("R3 pins", {9'b0, out_en_o, buf_lp_o, opamp_o, buf_bypass_o, interp_mode_o, range_o},
        {9'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11});
    wr(0, 16'h0219);
    chk("R3 pins", {9'b0, out_en_o, buf_lp_o, opamp_o, buf_bypass_o, interp_mode_o, range_o},
        {9'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01});

    // R6 immediate clear, R7 writes ignored
    wr(0, 16'h0018); wr(1, 16'h5555); @(negedge clk);
    chk("R6 pre", code_o, 16'h5555);
    @(negedge clk);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = 0; bus_wdata_i = 16'h0008;
    @(negedge clk); bus_sel_i = 0; bus_we_i = 0;
    chk("R6 code", code_o, 16'h0);
    rd(1, r); chk("R6 data", r, 16'h0);
    wr(1, 16'h7777); @(negedge clk);
    rd(1, r); chk("R7 data", r, 16'h0);
    chk("R7 code", code_o, 16'h0);
    wr(0, 16'h0018); @(negedge clk);
    chk("R7 after", code_o, 16'h0);

    // R5 timer-paced update
    wr(0, 16'h0038); wr(1, 16'h1111); idle(5);
    chk("R5 hold", code_o, 16'h0);
    timer_i = 1;
    idle(2); chk("R5 early", code_o, 16'h0);
    idle(1); chk("R5 load", code_o, 16'h1111);
    wr(1, 16'h2222); idle(4);
    chk("R5 level", code_o, 16'h1111);
    timer_i = 0; idle(4);
    chk("R5 fall", code_o, 16'h1111);
    timer_i = 1; idle(3);
    chk("R5 reload", code_o, 16'h2222);
    timer_i = 0;

    // R9 interpolation enable
    wr(0, 16'h0010); wr(0, 16'h001C);
    count_pulses(64, cnt, first);
    chk("R9 div16 count", 16'(cnt), 16'd4);
    chk("R9 div16 first", 16'(first), 16'd16);
    wr(0, 16'h0010); wr(0, 16'h0018);
    count_pulses(64, cnt, first);
    chk("R9 div32 count", 16'(cnt), 16'd2);
    chk("R9 div32 first", 16'(first), 16'd32);
    wr(0, 16'h0014);
    count_pulses(64, cnt, first);
    chk("R9 off", 16'(cnt), 16'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule